// File: doc/BRIEF.md
# Gain and Hard-Clip Distortion Stage

This block turns clean 8-bit signed audio samples, arriving at an audio rate of 44 100 Hz with a one-cycle valid strobe, into a distorted signal. Each sample is multiplied by an adjustable gain, limited symmetrically to a programmable threshold, and then scaled down by a volume factor. The higher the gain relative to the threshold, the earlier the waveform flattens against the limits and the harsher the distortion becomes. A bypass switch routes the raw sample to the output instead.

The three settings share one rotary encoder with quadrature A/B contacts and a push contact. Two slide switches pick which setting the encoder changes. Each detent step moves that setting by one unit and stops at its limits. Pressing the push contact returns the selected setting to its power-up value. The encoder contacts are synchronised and debounced inside the block, so they can be wired straight to the panel.

Top module: `fuzz_stage`

## Requirements
- R1: After reset the output is 0, the gain is 1.0 (raw code 16), the threshold is 127 and the volume is 15.
- R2: The output is registered: it takes its new value on the clock edge at which `smp_vld` is high and keeps its value on every edge at which `smp_vld` is low.
- R3: With `sw_bypass` high the output becomes the input sample unchanged.
- R4: With bypass off the sample is multiplied by the gain code (unsigned 4.4 fixed point, codes 16 to 255) and divided by 16 with rounding toward minus infinity, giving a 12-bit signed value.
- R5: The 12-bit value is hard clipped: values above +T become +T and values below -T become -T, where T is the threshold.
- R6: The clipped value is multiplied by the volume (0 to 15) and divided by 16 with rounding toward minus infinity, and this is the output.
- R7: `sw_sel` chooses the target of the encoder: 00 gain, 01 threshold, 10 volume. A rising edge of the debounced A contact while B is low raises the target by one unit; while B is high it lowers it by one unit.
- R8: Settings saturate at their limits: gain 16 to 255, threshold 8 to 127, volume 0 to 15.
- R9: A change on an encoder contact that lasts fewer than `DEB_CYC` clock cycles after synchronisation has no effect.
- R10: A debounced press of the push contact sets the selected setting back to its reset value.
- R11: With `sw_sel` = 11 encoder steps and pushes change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 8 | Signed input sample |
| smp_vld | input | 1 | Input sample strobe, one cycle per sample |
| sw_bypass | input | 1 | High passes the sample through without effect |
| sw_sel | input | 2 | Encoder target: 00 gain, 01 threshold, 10 volume, 11 none |
| knob_a | input | 1 | Encoder contact A, asynchronous |
| knob_b | input | 1 | Encoder contact B, asynchronous |
| knob_push | input | 1 | Encoder push contact, asynchronous |
| smp_out | output | 8 | Signed output sample |

## Verification
A processed sample is due on the same edge that samples `smp_vld`, so the bench drives inputs on the falling edge and compares the output with its reference model on every following falling edge, which also checks that the output holds between strobes. An encoder change reaches a setting two synchroniser cycles plus `DEB_CYC` debounce cycles plus two register cycles after the contact moves. The bench therefore holds each contact phase for twelve cycles with `DEB_CYC` = 4 and only updates its model and sends samples after a full detent, so every compared sample sees settled settings.

// File: rtl/fuzz_pkg.sv
package fuzz_pkg;
    localparam int SMP_W     = 8;
    localparam int GAIN_W    = 8;
    localparam int GAIN_FRAC = 4;
    localparam int PROD_W    = 12;
    localparam int VOL_W     = 4;
    localparam int VOL_SH    = 4;

    localparam logic [GAIN_W-1:0] GAIN_MIN = 8'd16;
    localparam logic [GAIN_W-1:0] GAIN_MAX = 8'd255;
    localparam logic [GAIN_W-1:0] GAIN_DEF = 8'd16;
    localparam logic [SMP_W-1:0]  THR_MIN  = 8'd8;
    localparam logic [SMP_W-1:0]  THR_MAX  = 8'd127;
    localparam logic [SMP_W-1:0]  THR_DEF  = 8'd127;
    localparam logic [VOL_W-1:0]  VOL_MIN  = 4'd0;
    localparam logic [VOL_W-1:0]  VOL_MAX  = 4'd15;
    localparam logic [VOL_W-1:0]  VOL_DEF  = 4'd15;

    typedef enum logic [1:0] {
        SEL_GAIN = 2'b00,
        SEL_THR  = 2'b01,
        SEL_VOL  = 2'b10,
        SEL_NONE = 2'b11
    } knob_sel_e;
endpackage

// File: rtl/fuzz_deb.sv
module fuzz_deb #(
    parameter int DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CNT_W = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw};
        if (st_q.sync[1] == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_W'(DEB_CYC - 1)) begin
            st_d.stable = st_q.sync[1];
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean = st_q.stable;
endmodule

// File: rtl/fuzz_knob_ctrl.sv
module fuzz_knob_ctrl
    import fuzz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_clean,
    input  logic              b_clean,
    input  logic              push_clean,
    input  logic [1:0]        sel,
    output logic [GAIN_W-1:0] gain,
    output logic [SMP_W-1:0]  thr,
    output logic [VOL_W-1:0]  vol
);
    typedef struct packed {
        logic              a_prev;
        logic              push_prev;
        logic [GAIN_W-1:0] gain;
        logic [SMP_W-1:0]  thr;
        logic [VOL_W-1:0]  vol;
    } knob_t;

    knob_t st_d, st_q;
    logic  step_up, step_dn, push_hit;

    always_comb begin
        step_up  = a_clean && !st_q.a_prev && !b_clean;
        step_dn  = a_clean && !st_q.a_prev &&  b_clean;
        push_hit = push_clean && !st_q.push_prev;

        st_d           = st_q;
        st_d.a_prev    = a_clean;
        st_d.push_prev = push_clean;

        case (knob_sel_e'(sel))
            SEL_GAIN: begin
                if (push_hit)                           st_d.gain = GAIN_DEF;
                else if (step_up && st_q.gain < GAIN_MAX) st_d.gain = st_q.gain + 1'b1;
                else if (step_dn && st_q.gain > GAIN_MIN) st_d.gain = st_q.gain - 1'b1;
            end
            SEL_THR: begin
                if (push_hit)                           st_d.thr = THR_DEF;
                else if (step_up && st_q.thr < THR_MAX) st_d.thr = st_q.thr + 1'b1;
                else if (step_dn && st_q.thr > THR_MIN) st_d.thr = st_q.thr - 1'b1;
            end
            SEL_VOL: begin
                if (push_hit)                           st_d.vol = VOL_DEF;
                else if (step_up && st_q.vol < VOL_MAX) st_d.vol = st_q.vol + 1'b1;
                else if (step_dn && st_q.vol > VOL_MIN) st_d.vol = st_q.vol - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.gain      <= GAIN_DEF;
            st_q.thr       <= THR_DEF;
            st_q.vol       <= VOL_DEF;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain = st_q.gain;
    assign thr  = st_q.thr;
    assign vol  = st_q.vol;
endmodule

// File: rtl/fuzz_datapath.sv
module fuzz_datapath
    import fuzz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic              smp_vld,
    input  logic              bypass,
    input  logic [GAIN_W-1:0] gain,
    input  logic [SMP_W-1:0]  thr,
    input  logic [VOL_W-1:0]  vol,
    output logic [SMP_W-1:0]  smp_out
);
    localparam int MUL_W  = SMP_W + GAIN_W + 1;
    localparam int VMUL_W = SMP_W + VOL_W + 1;

    typedef struct packed {
        logic [SMP_W-1:0] out;
    } dp_t;

    dp_t st_d, st_q;

    logic signed [MUL_W-1:0]  prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] lim_hi, lim_lo, clip12;
    logic signed [SMP_W-1:0]  clip8;
    logic signed [VMUL_W-1:0] vprod;
    logic        [SMP_W-1:0]  effect;

    always_comb begin
        prod   = $signed(smp_in) * $signed({1'b0, gain});
        scaled = PROD_W'(prod >>> GAIN_FRAC);

        lim_hi = $signed(PROD_W'(thr));
        lim_lo = -lim_hi;
        if (scaled > lim_hi)      clip12 = lim_hi;
        else if (scaled < lim_lo) clip12 = lim_lo;
        else                      clip12 = scaled;
        clip8  = SMP_W'(clip12);

        vprod  = clip8 * $signed({1'b0, vol});
        effect = SMP_W'(vprod >>> VOL_SH);

        st_d = st_q;
        if (smp_vld) st_d.out = bypass ? smp_in : effect;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_out = st_q.out;
endmodule

// File: rtl/fuzz_stage.sv
module fuzz_stage
    import fuzz_pkg::*;
#(
    parameter int DEB_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             smp_vld,
    input  logic             sw_bypass,
    input  logic [1:0]       sw_sel,
    input  logic             knob_a,
    input  logic             knob_b,
    input  logic             knob_push,
    output logic [SMP_W-1:0] smp_out
);
    localparam int N_CONTACTS = 3;

    logic [N_CONTACTS-1:0] contact_raw, contact_clean;
    logic [GAIN_W-1:0]     gain_w;
    logic [SMP_W-1:0]      thr_w;
    logic [VOL_W-1:0]      vol_w;

    assign contact_raw = {knob_push, knob_b, knob_a};

    for (genvar i = 0; i < N_CONTACTS; i++) begin : g_deb
        fuzz_deb #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (contact_raw[i]),
            .clean(contact_clean[i])
        );
    end

    fuzz_knob_ctrl u_knob (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_clean   (contact_clean[0]),
        .b_clean   (contact_clean[1]),
        .push_clean(contact_clean[2]),
        .sel       (sw_sel),
        .gain      (gain_w),
        .thr       (thr_w),
        .vol       (vol_w)
    );

    fuzz_datapath u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_in (smp_in),
        .smp_vld(smp_vld),
        .bypass (sw_bypass),
        .gain   (gain_w),
        .thr    (thr_w),
        .vol    (vol_w),
        .smp_out(smp_out)
    );
endmodule

// File: rtl/fuzz_stage_chk.sv
module fuzz_stage_chk
    import fuzz_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SMP_W-1:0]  smp_in,
    input logic              smp_vld,
    input logic              sw_bypass,
    input logic [1:0]        sw_sel,
    input logic [SMP_W-1:0]  smp_out,
    input logic [GAIN_W-1:0] gain_q,
    input logic [SMP_W-1:0]  thr_q,
    input logic [VOL_W-1:0]  vol_q
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(smp_out));

    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && sw_bypass) |=> (smp_out == $past(smp_in)));

    a_r5_clip_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !sw_bypass) |=>
            (($signed(smp_out) <= $signed({1'b0, $past(thr_q)})) &&
             ($signed(smp_out) >= -$signed({1'b0, $past(thr_q)}))));

    a_r8_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q >= GAIN_MIN) && (thr_q >= THR_MIN) && (thr_q <= THR_MAX));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sel == 2'b11) |=> ($stable(gain_q) && $stable(thr_q) && $stable(vol_q)));
endmodule

bind fuzz_stage fuzz_stage_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_in   (smp_in),
    .smp_vld  (smp_vld),
    .sw_bypass(sw_bypass),
    .sw_sel   (sw_sel),
    .smp_out  (smp_out),
    .gain_q   (gain_w),
    .thr_q    (thr_w),
    .vol_q    (vol_w)
);

// File: tb/test_fuzz_stage.sv
module test_fuzz_stage;
    localparam int PH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp_in = '0;
    logic       smp_vld = 1'b0;
    logic       sw_bypass = 1'b0;
    logic [1:0] sw_sel = 2'b00;
    logic       knob_a = 1'b0;
    logic       knob_b = 1'b0;
    logic       knob_push = 1'b0;
    logic [7:0] smp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R2";

    int m_gain = 16, m_thr = 127, m_vol = 15;
    int m_out = 0;

    always #5 clk = ~clk;

    fuzz_stage #(.DEB_CYC(4)) i_fuzz_stage (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
        .sw_bypass(sw_bypass), .sw_sel(sw_sel), .knob_a(knob_a),
        .knob_b(knob_b), .knob_push(knob_push), .smp_out(smp_out)
    );

    function automatic int model(int s, bit byp, int g, int t, int v);
        int p, c;
        if (byp) return s;
        p = (s * g) >>> 4;
        if (p > t)       c = t;
        else if (p < -t) c = -t;
        else             c = p;
        return (c * v) >>> 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n)       m_out <= 0;
        else if (smp_vld) m_out <= model($signed(smp_in), sw_bypass, m_gain, m_thr, m_vol);
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) check(cur_req, $signed(smp_out), m_out);
    end

    task automatic wait_ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic step(bit up);
        if (up) begin
            knob_a = 1'b1; wait_ph();
            knob_b = 1'b1; wait_ph();
            knob_a = 1'b0; wait_ph();
            knob_b = 1'b0; wait_ph();
        end else begin
            knob_b = 1'b1; wait_ph();
            knob_a = 1'b1; wait_ph();
            knob_b = 1'b0; wait_ph();
            knob_a = 1'b0; wait_ph();
        end
        case (sw_sel)
            2'b00: m_gain = up ? (m_gain < 255 ? m_gain + 1 : 255) : (m_gain > 16 ? m_gain - 1 : 16);
            2'b01: m_thr  = up ? (m_thr < 127 ? m_thr + 1 : 127) : (m_thr > 8 ? m_thr - 1 : 8);
            2'b10: m_vol  = up ? (m_vol < 15 ? m_vol + 1 : 15) : (m_vol > 0 ? m_vol - 1 : 0);
            default: ;
        endcase
    endtask

    task automatic steps(bit up, int n);
        for (int i = 0; i < n; i++) step(up);
    endtask

    task automatic push();
        knob_push = 1'b1; wait_ph();
        knob_push = 1'b0; wait_ph();
        case (sw_sel)
            2'b00: m_gain = 16;
            2'b01: m_thr  = 127;
            2'b10: m_vol  = 15;
            default: ;
        endcase
    endtask

    task automatic send(int s, bit byp, string req, int exp);
        smp_in = 8'(s); sw_bypass = byp; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        check(req, $signed(smp_out), exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset output", $signed(smp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output after reset", $signed(smp_out), 0);

        cur_req = "R1";
        send(100, 0, "R1 default settings", 93);
        send(64, 0, "R6 default volume", 60);
        cur_req = "R2";
        repeat (6) @(negedge clk);

        cur_req = "R3";
        send(-128, 1, "R3 bypass", -128);
        send(127, 1, "R3 bypass", 127);
        send(5, 1, "R3 bypass", 5);

        cur_req = "R8";
        sw_sel = 2'b10;
        step(1'b1);
        send(64, 0, "R8 volume top limit", 60);
        cur_req = "R7";
        steps(1'b0, 2);
        send(64, 0, "R7 volume down", 52);
        cur_req = "R10";
        push();
        send(64, 0, "R10 push restores volume", 60);

        cur_req = "R4";
        sw_sel = 2'b00;
        steps(1'b1, 16);
        send(50, 0, "R4 gain 2.0", 93);
        cur_req = "R5";
        send(100, 0, "R5 clip high", 119);
        send(-100, 0, "R5 clip low", -120);

        cur_req = "R8";
        sw_sel = 2'b01;
        steps(1'b0, 130);
        send(3, 0, "R5 below threshold", 5);
        send(60, 0, "R8 threshold floor", 7);
        send(-60, 0, "R8 threshold floor low side", -8);
        push();

        sw_sel = 2'b00;
        steps(1'b1, 230);
        send(1, 0, "R8 gain top limit", 14);
        send(-128, 0, "R4 R5 largest product", -120);

        cur_req = "R9";
        sw_sel = 2'b10;
        knob_a = 1'b1; @(negedge clk); @(negedge clk);
        knob_a = 1'b0; wait_ph();
        knob_b = 1'b1; @(negedge clk); @(negedge clk);
        knob_a = 1'b1; @(negedge clk);
        knob_a = 1'b0; knob_b = 1'b0; wait_ph();
        send(64, 0, "R9 short glitch ignored", 119);

        cur_req = "R11";
        sw_sel = 2'b11;
        steps(1'b0, 3);
        push();
        send(64, 0, "R11 no target", 119);

        cur_req = "R6";
        sw_sel = 2'b10;
        steps(1'b0, 20);
        send(100, 0, "R6 volume zero", 0);
        steps(1'b1, 8);
        send(100, 0, "R6 volume half", 63);
        send(-100, 0, "R6 volume half negative", -64);

        cur_req = "R4";
        sw_sel = 2'b00;
        push();
        sw_sel = 2'b01;
        steps(1'b0, 40);
        for (int i = 0; i < 300; i++) begin
            int s;
            bit b;
            s = int'($urandom_range(255)) - 128;
            b = ($urandom_range(3) == 0);
            smp_in = 8'(s); sw_bypass = b; smp_vld = 1'b1;
            @(negedge clk);
            smp_vld = 1'b0;
            check("R4 R5 R6 random", $signed(smp_out), model(s, b, m_gain, m_thr, m_vol));
            if ($urandom_range(1) == 1) @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule